// File: doc/BRIEF.md
# Priority Flow Rule Matcher

This block classifies packets in the data plane of a software-defined switch. It keeps a small table of forwarding rules. Each rule has a match condition over four header fields, a priority and a set of egress ports. Header parsing happens upstream, so each cycle the block can take one packet's ingress port number, EtherType and IPv4 source and destination addresses. One clock later it reports whether a rule matched, which rule won, and the egress ports as a bitmask. A packet that no rule claims is dropped, and its egress mask is all zeros.

Each rule field is either compared exactly or marked as a wildcard. A rule fires only when all four of its field conditions hold. When several rules fire, the one with the largest priority value wins. If their priorities are equal, the lowest table index wins. Port numbers are compared over their full 32 bits, so a number of 2^16 or above never matches a rule written for its low 16 bits.

Rules are loaded through a flat configuration port. One strobe writes every part of one table entry, including its enable bit.

Top module: `flow_rule_matcher`

## Requirements
- R1: A valid rule matches a packet only when every non-wildcard field equals the packet's field, compared over the field's full width (port 32 bits, EtherType 16 bits, each address 32 bits).
- R2: A field whose wildcard bit is set in a rule never prevents that rule from matching, whatever the packet carries in that field.
- R3: A lookup that matches no rule reports out_hit low, out_egress all zeros and out_rule zero, with out_valid high.
- R4: On a hit, out_egress equals the egress bitmask stored in the winning rule. Bit k of the mask means egress port k, and more than one bit may be set.
- R5: Among the matching rules, the one with the numerically largest priority value wins, whatever its table index.
- R6: Among matching rules that share the top priority, the rule with the lowest index wins.
- R7: Port numbers up to 0xFFFFFF00 are held and compared as 32-bit values. A rule for port 1 does not match port 0x00010001, and a rule for port 0xFFFFFF00 does not match port 0x0000FF00.
- R8: After reset every rule is disabled. A rule written with its enable bit low never matches.
- R9: The result appears on the clock edge after a cycle with in_valid high, together with out_valid high. In a cycle after in_valid was low, out_valid, out_hit, out_rule and out_egress are all low.
- R10: A rule write acts on lookups presented in later cycles. A lookup presented in the same cycle as the write sees the old table contents.
- R11: On a hit, out_rule carries the table index of the winning rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for one table entry |
| cfg_idx | input | IDX_W (3) | Index of the entry to write |
| cfg_valid | input | 1 | Enable bit for the entry |
| cfg_prio | input | PRIO_W (8) | Priority value; larger wins |
| cfg_egress | input | NUM_EGRESS (3) | Egress port bitmask |
| cfg_port | input | 32 | Ingress port number to match |
| cfg_port_any | input | 1 | Wildcard for the ingress port |
| cfg_etype | input | 16 | EtherType to match |
| cfg_etype_any | input | 1 | Wildcard for the EtherType |
| cfg_sip | input | 32 | Source IPv4 address to match |
| cfg_sip_any | input | 1 | Wildcard for the source address |
| cfg_dip | input | 32 | Destination IPv4 address to match |
| cfg_dip_any | input | 1 | Wildcard for the destination address |
| in_valid | input | 1 | A packet's header fields are present |
| in_port | input | 32 | Packet ingress port number |
| in_etype | input | 16 | Packet EtherType |
| in_sip | input | 32 | Packet source IPv4 address |
| in_dip | input | 32 | Packet destination IPv4 address |
| out_valid | output | 1 | Lookup result strobe |
| out_hit | output | 1 | A rule matched |
| out_rule | output | IDX_W (3) | Index of the winning rule |
| out_egress | output | NUM_EGRESS (3) | Egress bitmask; zero means drop |

## Verification
The bench targets the port aliasing case. A design that narrowed the port compare would send port 0x00010001 to a rule written for port 1. It also uses a rule parked on 0xFFFFFF00, which such a design would hand to port 0xFF00. Priority is tested in both directions. A high-index rule with a larger value must beat a low-index one, which catches a fixed-order arbiter. A tie must go to the lower index, which catches a comparison that lets later equals take over. Other cases are a rule disabled and re-enabled in place, and a write issued in the same cycle as a lookup. A design that bypassed the write into the compare would answer that lookup from the new contents.

// File: rtl/frm_pkg.sv
package frm_pkg;

  localparam int PORT_W  = 32;
  localparam int ETYPE_W = 16;
  localparam int IPV4_W  = 32;

  typedef struct packed {
    logic [PORT_W-1:0]  port;
    logic [ETYPE_W-1:0] etype;
    logic [IPV4_W-1:0]  src_ip;
    logic [IPV4_W-1:0]  dst_ip;
  } hdr_key_t;

  typedef struct packed {
    logic port;
    logic etype;
    logic src_ip;
    logic dst_ip;
  } wild_t;

  // One field passes when wildcarded or equal over its full width.
  function automatic logic field_pass32(input logic any, input logic [31:0] want,
                                        input logic [31:0] got);
    return any || (want == got);
  endfunction

  function automatic logic field_pass16(input logic any, input logic [15:0] want,
                                        input logic [15:0] got);
    return any || (want == got);
  endfunction

  // All four field conditions are ANDed.
  function automatic logic key_hit(input hdr_key_t want, input wild_t any,
                                   input hdr_key_t got);
    return field_pass32(any.port,   want.port,   got.port)
        && field_pass16(any.etype,  want.etype,  got.etype)
        && field_pass32(any.src_ip, want.src_ip, got.src_ip)
        && field_pass32(any.dst_ip, want.dst_ip, got.dst_ip);
  endfunction

endpackage

// File: rtl/frm_rule_store.sv
module frm_rule_store
  import frm_pkg::*;
#(
  parameter int NUM_RULES  = 8,
  parameter int NUM_EGRESS = 3,
  parameter int PRIO_W     = 8,
  localparam int IDX_W     = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [IDX_W-1:0]                     wr_idx,
  input  logic                                 wr_valid,
  input  logic [PRIO_W-1:0]                    wr_prio,
  input  logic [NUM_EGRESS-1:0]                wr_egress,
  input  hdr_key_t                             wr_key,
  input  wild_t                                wr_wild,
  output logic [NUM_RULES-1:0]                 rule_valid,
  output logic [NUM_RULES-1:0][PRIO_W-1:0]     rule_prio,
  output logic [NUM_RULES-1:0][NUM_EGRESS-1:0] rule_egress,
  output hdr_key_t [NUM_RULES-1:0]             rule_key,
  output wild_t [NUM_RULES-1:0]                rule_wild
);

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rule_valid[i]  <= 1'b0;
        rule_prio[i]   <= '0;
        rule_egress[i] <= '0;
        rule_key[i]    <= '0;
        rule_wild[i]   <= '0;
      end else if (sel) begin
        rule_valid[i]  <= wr_valid;
        rule_prio[i]   <= wr_prio;
        rule_egress[i] <= wr_egress;
        rule_key[i]    <= wr_key;
        rule_wild[i]   <= wr_wild;
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rule_valid[$past(wr_idx)] == $past(wr_valid))
           && (rule_prio[$past(wr_idx)] == $past(wr_prio))) // R10
    else $error("write did not land in the addressed entry");

endmodule

// File: rtl/frm_rule_compare.sv
module frm_rule_compare
  import frm_pkg::*;
#(
  parameter int NUM_RULES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  hdr_key_t                 pkt_key,
  input  logic [NUM_RULES-1:0]     rule_valid,
  input  hdr_key_t [NUM_RULES-1:0] rule_key,
  input  wild_t [NUM_RULES-1:0]    rule_wild,
  output logic [NUM_RULES-1:0]     hit_vec
);

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_cmp
    logic key_ok;
    assign key_ok     = key_hit(rule_key[i], rule_wild[i], pkt_key);
    assign hit_vec[i] = rule_valid[i] && key_ok;

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !rule_valid[i] |-> !hit_vec[i]) // R8
      else $error("disabled rule %0d matched", i);

    AST_ALL_WILD_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (rule_valid[i] && (rule_wild[i] == 4'b1111)) |-> hit_vec[i]) // R2
      else $error("fully wildcarded rule %0d missed", i);
  end

endmodule

// File: rtl/frm_prio_select.sv
module frm_prio_select #(
  parameter int NUM_RULES = 8,
  parameter int PRIO_W    = 8,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_RULES-1:0]             hit_vec,
  input  logic [NUM_RULES-1:0][PRIO_W-1:0] rule_prio,
  output logic                             any_hit,
  output logic [IDX_W-1:0]                 win_idx
);

  logic [PRIO_W-1:0] best_prio;

  // Ascending scan; only a strictly larger value displaces, so ties keep the lower index.
  always_comb begin
    any_hit   = 1'b0;
    win_idx   = '0;
    best_prio = '0;
    for (int i = 0; i < NUM_RULES; i++) begin
      if (hit_vec[i] && (!any_hit || (rule_prio[i] > best_prio))) begin
        any_hit   = 1'b1;
        win_idx   = IDX_W'(i);
        best_prio = rule_prio[i];
      end
    end
  end

  AST_WIN_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hit_vec[win_idx]) // R11
    else $error("winner index points at a non-matching rule");

  AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> any_hit) // R3
    else $error("matching rule present but no hit");

  always_ff @(posedge clk) begin
    if (rst_n && any_hit) begin
      for (int i = 0; i < NUM_RULES; i++) begin
        if (hit_vec[i]) begin
          AST_NONE_HIGHER: assert (!(rule_prio[i] > rule_prio[win_idx])) // R5
            else $error("rule %0d outranks the winner", i);
          AST_TIE_LOW_IDX: assert (!((rule_prio[i] == rule_prio[win_idx]) && (IDX_W'(i) < win_idx))) // R6
            else $error("tie lost to a higher index at %0d", i);
        end
      end
    end
  end

endmodule

// File: rtl/flow_rule_matcher.sv
module flow_rule_matcher
  import frm_pkg::*;
#(
  parameter int NUM_RULES  = 8,
  parameter int NUM_EGRESS = 3,
  parameter int PRIO_W     = 8,
  localparam int IDX_W     = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic                  cfg_valid,
  input  logic [PRIO_W-1:0]     cfg_prio,
  input  logic [NUM_EGRESS-1:0] cfg_egress,
  input  logic [31:0]           cfg_port,
  input  logic                  cfg_port_any,
  input  logic [15:0]           cfg_etype,
  input  logic                  cfg_etype_any,
  input  logic [31:0]           cfg_sip,
  input  logic                  cfg_sip_any,
  input  logic [31:0]           cfg_dip,
  input  logic                  cfg_dip_any,
  input  logic                  in_valid,
  input  logic [31:0]           in_port,
  input  logic [15:0]           in_etype,
  input  logic [31:0]           in_sip,
  input  logic [31:0]           in_dip,
  output logic                  out_valid,
  output logic                  out_hit,
  output logic [IDX_W-1:0]      out_rule,
  output logic [NUM_EGRESS-1:0] out_egress
);

  hdr_key_t wr_key, pkt_key;
  wild_t    wr_wild;

  assign wr_key  = '{port: cfg_port, etype: cfg_etype, src_ip: cfg_sip, dst_ip: cfg_dip};
  assign wr_wild = '{port: cfg_port_any, etype: cfg_etype_any,
                     src_ip: cfg_sip_any, dst_ip: cfg_dip_any};
  assign pkt_key = '{port: in_port, etype: in_etype, src_ip: in_sip, dst_ip: in_dip};

  logic [NUM_RULES-1:0]                 rule_valid;
  logic [NUM_RULES-1:0][PRIO_W-1:0]     rule_prio;
  logic [NUM_RULES-1:0][NUM_EGRESS-1:0] rule_egress;
  hdr_key_t [NUM_RULES-1:0]             rule_key;
  wild_t [NUM_RULES-1:0]                rule_wild;
  logic [NUM_RULES-1:0]                 hit_vec;
  logic                                 any_hit;
  logic [IDX_W-1:0]                     win_idx;
  logic [NUM_EGRESS-1:0]                win_egress;

  frm_rule_store #(
    .NUM_RULES(NUM_RULES), .NUM_EGRESS(NUM_EGRESS), .PRIO_W(PRIO_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid), .wr_prio(cfg_prio),
    .wr_egress(cfg_egress), .wr_key(wr_key), .wr_wild(wr_wild),
    .rule_valid(rule_valid), .rule_prio(rule_prio), .rule_egress(rule_egress),
    .rule_key(rule_key), .rule_wild(rule_wild)
  );

  frm_rule_compare #(.NUM_RULES(NUM_RULES)) u_cmp (
    .clk(clk), .rst_n(rst_n), .pkt_key(pkt_key),
    .rule_valid(rule_valid), .rule_key(rule_key), .rule_wild(rule_wild),
    .hit_vec(hit_vec)
  );

  frm_prio_select #(.NUM_RULES(NUM_RULES), .PRIO_W(PRIO_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .rule_prio(rule_prio),
    .any_hit(any_hit), .win_idx(win_idx)
  );

  assign win_egress = any_hit ? rule_egress[win_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_rule   <= '0;
      out_egress <= '0;
    end else begin
      out_valid  <= in_valid;
      out_hit    <= in_valid && any_hit;
      out_rule   <= (in_valid && any_hit) ? win_idx : '0;
      out_egress <= in_valid ? win_egress : '0;
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) // R9
    else $error("result strobe missing");

  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_hit && (out_egress == '0))) // R9
    else $error("outputs active without a lookup");

  AST_MISS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> ((out_egress == '0) && (out_rule == '0))) // R3
    else $error("miss forwarded a packet");

endmodule

// File: tb/sim_flow_rule_matcher.sv
`timescale 1ns/1ps
module sim_flow_rule_matcher;

  localparam int N  = 8;
  localparam int EG = 3;
  localparam int PW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic          cfg_valid = 1'b0;
  logic [PW-1:0] cfg_prio = '0;
  logic [EG-1:0] cfg_egress = '0;
  logic [31:0]   cfg_port = '0;
  logic          cfg_port_any = 1'b0;
  logic [15:0]   cfg_etype = '0;
  logic          cfg_etype_any = 1'b0;
  logic [31:0]   cfg_sip = '0;
  logic          cfg_sip_any = 1'b0;
  logic [31:0]   cfg_dip = '0;
  logic          cfg_dip_any = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   in_port = '0;
  logic [15:0]   in_etype = '0;
  logic [31:0]   in_sip = '0;
  logic [31:0]   in_dip = '0;
  logic          out_valid;
  logic          out_hit;
  logic [IW-1:0] out_rule;
  logic [EG-1:0] out_egress;

  always #2.5 clk = ~clk;

  flow_rule_matcher #(.NUM_RULES(N), .NUM_EGRESS(EG), .PRIO_W(PW)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Shadow table kept by the bench
  bit          sh_v[N];
  int          sh_p[N];
  int          sh_e[N];
  logic [31:0] sh_port[N], sh_sip[N], sh_dip[N];
  logic [15:0] sh_et[N];
  bit          sh_pa[N], sh_ea[N], sh_sa[N], sh_da[N];

  // Scoreboard queues
  bit    q_hit[$];
  int    q_idx[$];
  int    q_eg[$];
  string q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Reference: scan from the top index down, a rule of equal-or-higher value takes over.
  task automatic predict(input logic [31:0] p, input logic [15:0] e,
                         input logic [31:0] s, input logic [31:0] d,
                         output bit hit, output int idx, output int eg);
    hit = 0; idx = 0; eg = 0;
    for (int i = N - 1; i >= 0; i--) begin
      bit m;
      m = sh_v[i] && (sh_pa[i] || sh_port[i] === p) && (sh_ea[i] || sh_et[i] === e)
          && (sh_sa[i] || sh_sip[i] === s) && (sh_da[i] || sh_dip[i] === d);
      if (m && (!hit || sh_p[i] >= sh_p[idx])) begin
        hit = 1; idx = i; eg = sh_e[i];
      end
    end
  endtask

  task automatic drive_cfg(input int idx, input bit v, input int prio, input int eg,
                           input logic [31:0] p, input bit pa, input logic [15:0] e,
                           input bit ea, input logic [31:0] s, input bit sa,
                           input logic [31:0] d, input bit da);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_valid = v; cfg_prio = PW'(prio);
    cfg_egress = EG'(eg); cfg_port = p; cfg_port_any = pa; cfg_etype = e;
    cfg_etype_any = ea; cfg_sip = s; cfg_sip_any = sa; cfg_dip = d; cfg_dip_any = da;
  endtask

  task automatic shadow_cfg(input int idx, input bit v, input int prio, input int eg,
                            input logic [31:0] p, input bit pa, input logic [15:0] e,
                            input bit ea, input logic [31:0] s, input bit sa,
                            input logic [31:0] d, input bit da);
    sh_v[idx] = v; sh_p[idx] = prio; sh_e[idx] = eg; sh_port[idx] = p; sh_pa[idx] = pa;
    sh_et[idx] = e; sh_ea[idx] = ea; sh_sip[idx] = s; sh_sa[idx] = sa;
    sh_dip[idx] = d; sh_da[idx] = da;
  endtask

  task automatic drive_pkt(input logic [31:0] p, input logic [15:0] e,
                           input logic [31:0] s, input logic [31:0] d, input string tag);
    bit h; int ix; int eg;
    predict(p, e, s, d, h, ix, eg);
    in_valid = 1; in_port = p; in_etype = e; in_sip = s; in_dip = d;
    q_hit.push_back(h); q_idx.push_back(ix); q_eg.push_back(eg); q_tag.push_back(tag);
  endtask

  task automatic wr(input int idx, input bit v, input int prio, input int eg,
                    input logic [31:0] p, input bit pa, input logic [15:0] e,
                    input bit ea, input logic [31:0] s, input bit sa,
                    input logic [31:0] d, input bit da);
    @(negedge clk);
    in_valid = 0;
    drive_cfg(idx, v, prio, eg, p, pa, e, ea, s, sa, d, da);
    shadow_cfg(idx, v, prio, eg, p, pa, e, ea, s, sa, d, da);
  endtask

  task automatic look(input logic [31:0] p, input logic [15:0] e,
                      input logic [31:0] s, input logic [31:0] d, input string tag);
    @(negedge clk);
    cfg_we = 0;
    drive_pkt(p, e, s, d, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
  endtask

  // Monitor: results are registered, so at a falling edge they belong to the oldest entry.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_hit.size() == 0) begin
        check(0, "R9", "unexpected result strobe", 1, 0);
      end else begin
        bit h; int ix; int eg; string t;
        h = q_hit.pop_front(); ix = q_idx.pop_front();
        eg = q_eg.pop_front(); t = q_tag.pop_front();
        check(out_hit === h, t, "hit", int'(out_hit), int'(h));
        check(out_egress === EG'(eg), t, "egress", int'(out_egress), eg);
        check(out_rule === IW'(ix), t, "rule", int'(out_rule), ix);
      end
    end
  end

  localparam logic [31:0] IP_A = 32'h0A00_0001;
  localparam logic [31:0] IP_B = 32'h0A00_0002;
  localparam logic [31:0] IP_C = 32'hC0A8_0107;

  initial begin
    for (int i = 0; i < N; i++) shadow_cfg(i, 0, 0, 0, '0, 0, '0, 0, '0, 0, '0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_hit === 1'b0 && out_egress === '0, "R9",
          "reset outputs", int'({out_valid, out_hit, out_egress}), 0);
    look(32'd1, 16'h0800, IP_A, IP_B, "R8 empty table misses");
    // Exact rule at index 0
    wr(0, 1, 10, 3'b010, 32'd1, 0, 16'h0800, 0, IP_A, 0, IP_B, 0);
    look(32'd1, 16'h0800, IP_A, IP_B, "R1 R11 exact match");
    look(32'd1, 16'h0800, IP_A, IP_C, "R1 R3 dst differs");
    look(32'd1, 16'h86DD, IP_A, IP_B, "R1 etype differs");
    look(32'h0001_0001, 16'h0800, IP_A, IP_B, "R7 port aliasing");
    // Rule on the top legal port, other fields wildcarded
    wr(1, 1, 5, 3'b101, 32'hFFFF_FF00, 0, 16'h0, 1, 32'h0, 1, 32'h0, 1);
    look(32'hFFFF_FF00, 16'h1234, IP_C, IP_A, "R7 R4 R2 top port");
    look(32'h0000_FF00, 16'h1234, IP_C, IP_A, "R7 truncated port");
    // Catch-all, lower priority than rule 0
    wr(2, 1, 1, 3'b001, 32'h0, 1, 16'h0, 1, 32'h0, 1, 32'h0, 1);
    look(32'd9, 16'h0806, IP_C, IP_C, "R2 catch-all");
    look(32'd1, 16'h0800, IP_A, IP_B, "R5 higher priority wins");
    // Tie cases
    wr(3, 1, 1, 3'b100, 32'h0, 1, 16'h0, 1, 32'h0, 1, 32'h0, 1);
    wr(6, 1, 10, 3'b111, 32'd1, 0, 16'h0800, 0, IP_A, 0, IP_B, 0);
    look(32'd9, 16'h0806, IP_C, IP_C, "R6 tie at low priority");
    look(32'd1, 16'h0800, IP_A, IP_B, "R6 tie at high priority");
    // High index, higher priority
    wr(7, 1, 200, 3'b110, 32'h0, 1, 16'h86DD, 0, 32'h0, 1, 32'h0, 1);
    look(32'd1, 16'h86DD, IP_A, IP_B, "R5 R11 high index wins");
    look(32'd4, 16'h86DD, IP_B, IP_A, "R5 R4 back to back");
    // Disable rule 7
    wr(7, 0, 200, 3'b110, 32'h0, 1, 16'h86DD, 0, 32'h0, 1, 32'h0, 1);
    look(32'd1, 16'h86DD, IP_A, IP_B, "R8 disabled rule");
    // Write and lookup in the same cycle: old contents apply
    @(negedge clk);
    drive_pkt(32'd1, 16'h86DD, IP_A, IP_B, "R10 same cycle old table");
    drive_cfg(7, 1, 200, 3'b110, 32'h0, 1, 16'h86DD, 0, 32'h0, 1, 32'h0, 1);
    shadow_cfg(7, 1, 200, 3'b110, 32'h0, 1, 16'h86DD, 0, 32'h0, 1, 32'h0, 1);
    look(32'd1, 16'h86DD, IP_A, IP_B, "R10 next cycle new table");
    // Remove catch-alls to expose a miss among many rules
    wr(2, 0, 1, 3'b001, 32'h0, 1, 16'h0, 1, 32'h0, 1, 32'h0, 1);
    wr(3, 0, 1, 3'b100, 32'h0, 1, 16'h0, 1, 32'h0, 1, 32'h0, 1);
    look(32'd2, 16'h0800, IP_C, IP_C, "R3 miss drops");
    idle();
    idle();
    check(out_valid === 1'b0 && out_hit === 1'b0 && out_egress === '0, "R9",
          "idle outputs", int'({out_valid, out_hit, out_egress}), 0);
    check(q_hit.size() == 0, "R9", "results outstanding", q_hit.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule